// File: doc/BRIEF.md
# Push-Button Wiper Position Controller

This block keeps the tap position of a 32-position resistor ladder and moves it from two debounced push-buttons, one raising the position and one lowering it. A brief press moves the tap by one position. If the button stays down past a start delay, the block takes a second step and enters a repeating scan. In the scan it keeps stepping at a fixed interval for as long as the button is held. The position stops at both ends of the ladder and never wraps.

Each button reaches the block from its debouncer as two signals: a one-cycle pulse when a press is accepted, and a level that stays high while the button is down. All delays are counted in ticks of an external millisecond strobe. A preset pin, sampled during reset, chooses the start position: midscale or zero. When both buttons are active, lowering wins.

Top module: `tap_stepper`

## Requirements
- R1: While reset is active with `preset_zero` low, the position is loaded with midscale, code 16. That value is on `tap_code` in the first cycle after reset.
- R2: While reset is active with `preset_zero` high, the position is loaded with zero scale, code 0.
- R3: An accepted press pulse changes `tap_code` by exactly one code, on the clock edge that samples it. The code never moves by more than one per cycle.
- R4: A press released before START_TICKS ticks of holding have been counted gives that single step only.
- R5: A button held for START_TICKS counted ticks gives one more step on the tick that completes the count.
- R6: After that step, continued holding gives one further step every SCAN_TICKS ticks.
- R7: The position saturates at full scale, code 31, however long the raise button is held.
- R8: The position saturates at code 0, however long the lower button is held.
- R9: When both buttons are pressed or held together, the position decrements until it reaches code 0.
- R10: With no press pulse and no held level, the position does not change.
- R11: Releasing a button clears the hold timer. A new press therefore starts with a single step, not in the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| preset_zero | input | 1 | Reset value select: 1 gives zero scale, 0 gives midscale |
| up_press | input | 1 | Accepted raise press, one-cycle pulse |
| up_held | input | 1 | Raise button held level |
| dn_press | input | 1 | Accepted lower press, one-cycle pulse |
| dn_held | input | 1 | Lower button held level |
| tap_code | output | 5 | Registered wiper tap position |

## Verification
The bench builds the block with START_TICKS set to 8 and SCAN_TICKS set to 3, and raises the millisecond strobe every fourth clock. With these values, the start of the scan, several scan steps and both saturation ends all fit in a few hundred clocks. Short and long holds can then be placed on either side of the start threshold with a margin of one tick. The bench holds both buttons from near full scale, so the decrement priority is exercised all the way down to zero.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;
endpackage

// File: rtl/tap_dir_arbiter.sv
module tap_dir_arbiter
  import tap_pkg::*;
(
  input  logic up_press,
  input  logic up_held,
  input  logic dn_press,
  input  logic dn_held,
  input  logic scan_fire,
  output dir_e hold_dir,
  output logic step_up,
  output logic step_dn
);
  // lowering has priority over raising in both hold and press paths
  assign hold_dir = dn_held ? DIR_DN : (up_held ? DIR_UP : DIR_NONE);

  always_comb begin
    step_dn = dn_press | (scan_fire & (hold_dir == DIR_DN));
    step_up = ~step_dn & (up_press | (scan_fire & (hold_dir == DIR_UP)));
  end
endmodule

// File: rtl/tap_scan_timer.sv
module tap_scan_timer
  import tap_pkg::*;
#(
  parameter int START_TICKS = 800,
  parameter int SCAN_TICKS  = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  dir_e hold_dir,
  output logic scan_fire
);
  localparam int LIM = (START_TICKS > SCAN_TICKS) ? START_TICKS : SCAN_TICKS;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] START_L = CW'(START_TICKS);
  localparam logic [CW-1:0] SCAN_L  = CW'(SCAN_TICKS);

  logic [CW-1:0] cnt_q;
  logic          scanning_q;
  dir_e          prev_dir_q;
  logic          restart;
  logic [CW-1:0] limit;

  always_comb begin
    restart   = (hold_dir == DIR_NONE) || (hold_dir != prev_dir_q);
    limit     = scanning_q ? SCAN_L : START_L;
    scan_fire = !restart && ms_tick && ((cnt_q + 1'b1) == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      scanning_q <= 1'b0;
      prev_dir_q <= DIR_NONE;
    end else begin
      prev_dir_q <= hold_dir;
      if (restart) begin
        cnt_q      <= '0;
        scanning_q <= 1'b0;
      end else if (ms_tick) begin
        if (scan_fire) begin
          cnt_q      <= '0;
          scanning_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R11
  release_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_dir == DIR_NONE) |=> !scan_fire);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit);
endmodule

// File: rtl/tap_position.sv
module tap_position #(
  parameter int TAPS = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    preset_zero,
  input  logic                    step_up,
  input  logic                    step_dn,
  output logic [$clog2(TAPS)-1:0] tap_q
);
  localparam int PW = $clog2(TAPS);
  localparam logic [PW-1:0] FULL = PW'(TAPS - 1);
  localparam logic [PW-1:0] MID  = PW'(TAPS / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= preset_zero ? '0 : MID;
    end else if (step_dn) begin
      if (tap_q != '0) tap_q <= tap_q - 1'b1;
    end else if (step_up) begin
      if (tap_q != FULL) tap_q <= tap_q + 1'b1;
    end
  end

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, tap_q} == {1'b0, $past(tap_q)}) ||
    ({1'b0, tap_q} == {1'b0, $past(tap_q)} + 1'b1) ||
    ({1'b0, tap_q} + 1'b1 == {1'b0, $past(tap_q)}));

  // R7
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_q == FULL) |=> (tap_q >= FULL - 1'b1));

  // R8
  bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_q == '0) |=> (tap_q <= PW'(1)));
endmodule

// File: rtl/tap_stepper.sv
module tap_stepper
  import tap_pkg::*;
#(
  parameter int TAPS        = 32,
  parameter int START_TICKS = 800,
  parameter int SCAN_TICKS  = 250
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ms_tick,
  input  logic                    preset_zero,
  input  logic                    up_press,
  input  logic                    up_held,
  input  logic                    dn_press,
  input  logic                    dn_held,
  output logic [$clog2(TAPS)-1:0] tap_code
);
  localparam int PW = $clog2(TAPS);

  dir_e hold_dir;
  logic scan_fire;
  logic step_up;
  logic step_dn;

  tap_dir_arbiter u_arb (
    .up_press (up_press),
    .up_held  (up_held),
    .dn_press (dn_press),
    .dn_held  (dn_held),
    .scan_fire(scan_fire),
    .hold_dir (hold_dir),
    .step_up  (step_up),
    .step_dn  (step_dn)
  );

  tap_scan_timer #(
    .START_TICKS(START_TICKS),
    .SCAN_TICKS (SCAN_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ms_tick  (ms_tick),
    .hold_dir (hold_dir),
    .scan_fire(scan_fire)
  );

  tap_position #(.TAPS(TAPS)) u_pos (
    .clk        (clk),
    .rst        (rst),
    .preset_zero(preset_zero),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .tap_q      (tap_code)
  );

  // R1
  mid_preset_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(preset_zero)) |-> (tap_code == PW'(TAPS / 2)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_press && !dn_press && !up_held && !dn_held) |=> $stable(tap_code));

  // R9
  both_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (up_press && dn_press && tap_code != '0) |=> (tap_code + 1'b1 == $past(tap_code)));
endmodule

// File: tb/test_tap_stepper.sv
`timescale 1ns/1ps
module test_tap_stepper;
  localparam int START = 8;
  localparam int SCAN  = 3;

  logic clk = 0;
  logic rst = 1;
  logic ms_tick = 0;
  logic preset_zero = 0;
  logic up_press = 0, up_held = 0, dn_press = 0, dn_held = 0;
  logic [4:0] tap_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_pos, m_cnt, m_pdir;
  bit m_scan;

  always #2.5 clk = ~clk;

  tap_stepper #(.TAPS(32), .START_TICKS(START), .SCAN_TICKS(SCAN)) i_tap_stepper (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .preset_zero(preset_zero),
    .up_press(up_press), .up_held(up_held), .dn_press(dn_press), .dn_held(dn_held),
    .tap_code(tap_code)
  );

  // millisecond strobe: one cycle high in every four
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      ms_tick = (ph == 0);
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    int dir;
    bit fire, sd, su;
    if (rst) begin
      m_pos = preset_zero ? 0 : 16;
      m_cnt = 0; m_scan = 0; m_pdir = 0;
    end else begin
      dir = dn_held ? 2 : (up_held ? 1 : 0);
      fire = 0;
      if (dir == 0 || dir != m_pdir) begin
        m_cnt = 0; m_scan = 0;
      end else if (ms_tick) begin
        if (m_cnt + 1 == (m_scan ? SCAN : START)) begin
          fire = 1; m_cnt = 0; m_scan = 1;
        end else m_cnt = m_cnt + 1;
      end
      m_pdir = dir;
      sd = dn_press || (fire && dir == 2);
      su = up_press || (fire && dir == 1);
      if (sd) begin if (m_pos > 0) m_pos = m_pos - 1; end
      else if (su) begin if (m_pos < 31) m_pos = m_pos + 1; end
    end
  end

  // per-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (!done) begin
        checks++;
        if (int'(tap_code) != m_pos) begin
          failures++;
          $display("FAIL %s model compare: actual=%0d expected=%0d", cur_req, tap_code, m_pos);
        end
      end
    end
  end

  task automatic chk(string req, int exp);
    checks++;
    if (int'(tap_code) != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, tap_code, exp);
    end
  endtask

  task automatic do_reset(bit pz);
    @(negedge clk);
    preset_zero = pz; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  // press with pulse on the first cycle, hold level for n clocks
  task automatic press(bit up, bit dn, int n);
    @(negedge clk);
    up_press = up; dn_press = dn; up_held = up; dn_held = dn;
    @(negedge clk);
    up_press = 0; dn_press = 0;
    repeat (n - 1) @(negedge clk);
    up_held = 0; dn_held = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    do_reset(0);
    chk("R1", 16);

    cur_req = "R10";
    repeat (30) @(negedge clk);
    chk("R10", 16);

    cur_req = "R3";
    press(1, 0, 2);
    chk("R3", 17);
    press(0, 1, 2);
    chk("R3", 16);

    cur_req = "R4";
    press(1, 0, 20);
    chk("R4", 17);

    cur_req = "R5";
    press(1, 0, 40);
    chk("R5", 19);

    cur_req = "R6";
    press(1, 0, 72);
    chk("R6", 24);

    cur_req = "R11";
    press(1, 0, 20);
    chk("R11", 25);

    cur_req = "R7";
    press(1, 0, 400);
    chk("R7", 31);

    cur_req = "R9";
    press(1, 1, 2);
    chk("R9", 30);
    press(1, 1, 600);
    chk("R9", 0);

    cur_req = "R8";
    press(0, 1, 200);
    chk("R8", 0);

    cur_req = "R10";
    repeat (20) @(negedge clk);
    chk("R10", 0);

    cur_req = "R2";
    do_reset(1);
    chk("R2", 0);
    press(1, 0, 2);
    chk("R3", 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule